// File: doc/BRIEF.md
# Byte-Stuffed Stream Link over an SPI Slave Port

This block turns an SPI slave port into a pair of continuous byte streams, one in each direction. Every byte the master clocks is a two-way exchange. When the slave has nothing queued to send, it fills the slot with a reserved filler code. Any payload byte that matches a reserved code is sent as a two-byte escape pair, so the filler can never be mistaken for data. The receive path undoes the escapes and discards fillers. Bytes are handed to local logic through a valid/ready stream.

The slave cannot throttle the master's clock, so it uses in-band symbols. When its receive queue fills past a high mark, it queues a pause symbol for the master. When the queue drains below a low mark, it queues a continue symbol. The master needs no matching symbols in the other direction: it throttles simply by not clocking. Deasserting the select line returns both the escape encoder and the escape decoder to their neutral state.

The SPI lines are oversampled in the system clock domain. Clock polarity, clock phase and bit order are static configuration inputs.

Top module: `spi_stuffed_link`

## Requirements
- R1: When no payload, pending escape tail or flow symbol is waiting at the start of a byte slot, the slave shifts out the filler code 0x7E. After reset, and before the first select assertion, the shift register already holds 0x7E.
- R2: A transmit payload byte equal to 0x7E, 0x7D, 0x13 or 0x11 goes out as the two bytes 0x7D and (byte XOR 0x20). All other payload bytes go out unchanged and in order.
- R3: On receive, 0x7D followed by any byte delivers that byte XOR 0x20. An unescaped 0x7E, 0x13 or 0x11 is discarded. Every other byte is delivered in order.
- R4: When the receive queue holds 12 or more bytes, the pause symbol 0x13 is queued once. The first slot loaded after the symbol is queued carries it, which is the second slot after the slot whose byte filled the queue to 12. When the queue then falls below 4 bytes, the continue symbol 0x11 is queued once in the same way.
- R5: A queued flow symbol is sent before any waiting payload byte. The second byte of an escape pair always goes out in the slot directly after its 0x7D.
- R6: A rising edge on the select line (active low) clears any half-received escape on the receive side and any unsent escape tail on the transmit side. It also restarts the bit count for the next session.
- R7: All eight combinations of clock polarity (idle level), clock phase (0: sample on the leading edge, 1: sample on the trailing edge) and bit order (0: MSB first, 1: LSB first) carry bytes correctly.
- R8: Each direction is buffered by a 16-byte queue. tx_ready is low while 16 transmit bytes are waiting.
- R9: During and right after reset, rx_valid is low and tx_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the SPI lines are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on the leading edge, 1: sample on the trailing edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_miso | output | 1 | Serial data to the master |
| tx_valid | input | 1 | Transmit payload byte offered |
| tx_ready | output | 1 | Transmit queue can accept a byte |
| tx_data | input | 8 | Transmit payload byte |
| rx_valid | output | 1 | Received payload byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received payload byte |

## Verification
An encoder left in the wrong state shows up on MISO in the very next byte slot. A lost escape tail, a symbol wedged inside an escape pair, or a filler where a payload byte was due each produces a byte-for-byte mismatch against the arithmetically stuffed stream. A decoder fault shows at rx_data as soon as the affected byte is popped: a byte not XORed after 0x7D, a reserved code that leaks through, or an escape carried across a select deassertion. A fault in the flow-control state machine is pinned to an exact slot, because the pause symbol must appear two slots after the twelfth received byte. A wrong polarity, phase or bit-order decode corrupts the first exchanged byte of a session, which the sweep over all eight modes exposes.

// File: rtl/sslink_pkg.sv
package sslink_pkg;

  localparam logic [7:0] CODE_IDLE   = 8'h7E;
  localparam logic [7:0] CODE_ESC    = 8'h7D;
  localparam logic [7:0] CODE_STOP   = 8'h13;
  localparam logic [7:0] CODE_RESUME = 8'h11;
  localparam logic [7:0] ESC_FLIP    = 8'h20;

  // What the byte held in the shift register stands for.
  typedef enum logic [2:0] {
    SLOT_IDLE,
    SLOT_CTL,
    SLOT_PLAIN,
    SLOT_ESC,
    SLOT_TAIL
  } slot_kind_e;

  function automatic logic is_reserved(input logic [7:0] b);
    return (b == CODE_IDLE) || (b == CODE_ESC) || (b == CODE_STOP) || (b == CODE_RESUME);
  endfunction

endpackage

// File: rtl/sslink_sync.sv
module sslink_sync #(
  parameter int               N       = 3,
  parameter logic [N-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= async_in[g];
        stab_q <= meta_q;
      end
    end
    assign sync_out[g] = stab_q;
  end

endmodule

// File: rtl/sslink_fifo.sv
module sslink_fifo #(
  parameter  int WIDTH = 8,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [LW-1:0]    level
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LW-1:0]    cnt_q, cnt_d;
  logic             full, empty;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == LW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign rd_data = mem_q[rd_ptr_q];
  assign level   = cnt_q;

  always_comb begin
    wr_ptr_d = wr_en ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = rd_en ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q + LW'(wr_en) - LW'(rd_en);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_ptr_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !full);
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> !empty);

endmodule

// File: rtl/sslink_encoder.sv
module sslink_encoder
  import sslink_pkg::*;
#(
  parameter int HI_MARK = 12,
  parameter int LO_MARK = 4,
  parameter int LVL_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_clr,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_head,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             commit,
  input  slot_kind_e       commit_kind,
  input  logic [7:0]       commit_byte,
  output logic [7:0]       sel_byte,
  output slot_kind_e       sel_kind,
  output logic             fifo_pop
);

  logic       tail_v_q, tail_v_d;
  logic [7:0] tail_q, tail_d;
  logic       paused_q, paused_d;
  logic       pend_v_q, pend_v_d;
  logic [7:0] pend_q, pend_d;

  // Flow-control symbol scheduling from the receive queue level.
  always_comb begin
    paused_d = paused_q;
    pend_v_d = pend_v_q;
    pend_d   = pend_q;
    if (commit && (commit_kind == SLOT_CTL) && (commit_byte == pend_q)) pend_v_d = 1'b0;
    if (!paused_q && (rx_level >= LVL_W'(HI_MARK))) begin
      paused_d = 1'b1;
      pend_v_d = 1'b1;
      pend_d   = CODE_STOP;
    end else if (paused_q && (rx_level < LVL_W'(LO_MARK))) begin
      paused_d = 1'b0;
      pend_v_d = 1'b1;
      pend_d   = CODE_RESUME;
    end
  end

  // Escape tail bookkeeping.
  always_comb begin
    tail_v_d = tail_v_q;
    tail_d   = tail_q;
    if (commit && (commit_kind == SLOT_TAIL)) tail_v_d = 1'b0;
    if (commit && (commit_kind == SLOT_ESC)) begin
      tail_v_d = 1'b1;
      tail_d   = fifo_head ^ ESC_FLIP;
    end
    if (link_clr) tail_v_d = 1'b0;
  end

  // Slot content priority: escape tail, flow symbol, payload, filler.
  always_comb begin
    if (tail_v_q) begin
      sel_byte = tail_q;
      sel_kind = SLOT_TAIL;
    end else if (pend_v_q) begin
      sel_byte = pend_q;
      sel_kind = SLOT_CTL;
    end else if (!fifo_empty) begin
      sel_byte = is_reserved(fifo_head) ? CODE_ESC : fifo_head;
      sel_kind = is_reserved(fifo_head) ? SLOT_ESC : SLOT_PLAIN;
    end else begin
      sel_byte = CODE_IDLE;
      sel_kind = SLOT_IDLE;
    end
  end

  assign fifo_pop = commit && !fifo_empty &&
                    ((commit_kind == SLOT_PLAIN) || (commit_kind == SLOT_ESC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_v_q <= 1'b0;
      tail_q   <= 8'h00;
      paused_q <= 1'b0;
      pend_v_q <= 1'b0;
      pend_q   <= CODE_RESUME;
    end else begin
      tail_v_q <= tail_v_d;
      tail_q   <= tail_d;
      paused_q <= paused_d;
      pend_v_q <= pend_v_d;
      pend_q   <= pend_d;
    end
  end

  // R5
  esc_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (commit_kind == SLOT_ESC)) |=>
      ((sel_byte != CODE_STOP) && (sel_byte != CODE_RESUME) && (sel_byte != CODE_IDLE)));
  // R4
  ctl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (commit_kind == SLOT_CTL)) |->
      ((commit_byte == CODE_STOP) || (commit_byte == CODE_RESUME)));

endmodule

// File: rtl/sslink_decoder.sv
module sslink_decoder
  import sslink_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_clr,
  input  logic       byte_done,
  input  logic [7:0] byte_in,
  input  logic       fifo_full,
  output logic       push,
  output logic [7:0] push_data
);

  logic esc_q, esc_d;

  always_comb begin
    push      = 1'b0;
    push_data = byte_in;
    esc_d     = esc_q;
    if (byte_done) begin
      if (esc_q) begin
        push      = !fifo_full;
        push_data = byte_in ^ ESC_FLIP;
        esc_d     = 1'b0;
      end else if (byte_in == CODE_ESC) begin
        esc_d = 1'b1;
      end else if (!is_reserved(byte_in)) begin
        push = !fifo_full;
      end
    end
    if (link_clr) esc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) esc_q <= 1'b0;
    else        esc_q <= esc_d;
  end

  // R3
  rx_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !esc_q && push) |-> !is_reserved(push_data));

endmodule

// File: rtl/spi_stuffed_link.sv
module spi_stuffed_link
  import sslink_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int HI_MARK    = 12,
  parameter int LO_MARK    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_cpol,
  input  logic       cfg_cpha,
  input  logic       cfg_lsb_first,
  input  logic       spi_sclk,
  input  logic       spi_mosi,
  input  logic       spi_ss_n,
  output logic       spi_miso,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data
);

  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_int  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_int  <= rst_meta_q;
    end
  end

  logic ss_s, mosi_s, sclk_s;
  sslink_sync #(.N(3), .RST_VAL(3'b100)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .async_in ({spi_ss_n, spi_mosi, spi_sclk}),
    .sync_out ({ss_s, mosi_s, sclk_s})
  );

  logic       sclk_prev_q, ss_prev_q;
  logic [2:0] bit_cnt_q, bit_cnt_d;
  logic [7:0] rx_sr_q, rx_sr_d, rx_next;
  logic [7:0] tx_sr_q, tx_sr_d;
  slot_kind_e tx_kind_q, tx_kind_d;
  logic       ss_act, rise, fall, lead, trail, samp, link_clr;
  logic       byte_done, commit, load;
  logic [2:0] out_idx;

  logic [7:0]       sel_byte;
  slot_kind_e       sel_kind;
  logic             tx_pop, tx_push, rx_push, rx_pop;
  logic [7:0]       tx_head, rx_push_data;
  logic [LVL_W-1:0] tx_level, rx_level;

  always_comb begin
    ss_act    = !ss_s;
    rise      = sclk_s && !sclk_prev_q;
    fall      = !sclk_s && sclk_prev_q;
    lead      = cfg_cpol ? fall : rise;
    trail     = cfg_cpol ? rise : fall;
    samp      = ss_act && (cfg_cpha ? trail : lead);
    link_clr  = ss_s && !ss_prev_q;
    rx_next   = cfg_lsb_first ? {mosi_s, rx_sr_q[7:1]} : {rx_sr_q[6:0], mosi_s};
    byte_done = samp && (bit_cnt_q == 3'd7);
    commit    = samp && (bit_cnt_q == 3'd0);
    load      = !ss_act || byte_done;
    bit_cnt_d = !ss_act ? 3'd0 : (samp ? bit_cnt_q + 3'd1 : bit_cnt_q);
    rx_sr_d   = rx_next;
    tx_sr_d   = sel_byte;
    tx_kind_d = sel_kind;
    out_idx   = cfg_lsb_first ? bit_cnt_q : (3'd7 - bit_cnt_q);
  end

  assign spi_miso = tx_sr_q[out_idx];

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      sclk_prev_q <= 1'b0;
      ss_prev_q   <= 1'b1;
      bit_cnt_q   <= 3'd0;
      rx_sr_q     <= 8'h00;
      tx_sr_q     <= CODE_IDLE;
      tx_kind_q   <= SLOT_IDLE;
    end else begin
      sclk_prev_q <= sclk_s;
      ss_prev_q   <= ss_s;
      bit_cnt_q   <= bit_cnt_d;
      if (samp) rx_sr_q <= rx_sr_d;
      if (load) begin
        tx_sr_q   <= tx_sr_d;
        tx_kind_q <= tx_kind_d;
      end
    end
  end

  assign tx_ready = (tx_level != LVL_W'(FIFO_DEPTH));
  assign tx_push  = tx_valid && tx_ready;
  assign rx_valid = (rx_level != '0);
  assign rx_pop   = rx_valid && rx_ready;

  sslink_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (tx_push),
    .wr_data (tx_data),
    .rd_en   (tx_pop),
    .rd_data (tx_head),
    .level   (tx_level)
  );

  sslink_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (rx_push),
    .wr_data (rx_push_data),
    .rd_en   (rx_pop),
    .rd_data (rx_data),
    .level   (rx_level)
  );

  sslink_encoder #(.HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .LVL_W(LVL_W)) enc_i (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .link_clr    (link_clr),
    .fifo_empty  (tx_level == '0),
    .fifo_head   (tx_head),
    .rx_level    (rx_level),
    .commit      (commit),
    .commit_kind (tx_kind_q),
    .commit_byte (tx_sr_q),
    .sel_byte    (sel_byte),
    .sel_kind    (sel_kind),
    .fifo_pop    (tx_pop)
  );

  sslink_decoder dec_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .link_clr  (link_clr),
    .byte_done (byte_done),
    .byte_in   (rx_next),
    .fifo_full (rx_level == LVL_W'(FIFO_DEPTH)),
    .push      (rx_push),
    .push_data (rx_push_data)
  );

endmodule

// File: tb/spi_stuffed_link_tb_top.sv
module spi_stuffed_link_tb_top;

  localparam int H = 6;  // system clocks per SPI half period

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpol, cpha, lsb;
  logic       sclk, mosi, ss_n, miso;
  logic       tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0] tx_data, rx_data;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] mo_buf [64];
  logic [7:0] mi_buf [64];
  logic [7:0] exp_buf [64];

  always #10 clk = ~clk;

  spi_stuffed_link dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_lsb_first(lsb),
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_ss_n(ss_n), .spi_miso(miso),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_reset(input int mode);
    rst_n = 1'b0;
    cpol = mode[0]; cpha = mode[1]; lsb = mode[2];
    sclk = mode[0]; ss_n = 1'b1; mosi = 1'b0;
    tx_valid = 1'b0; tx_data = 8'h00; rx_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi);
    mi = 8'h00;
    for (int i = 0; i < 8; i++) begin
      int k;
      k = lsb ? i : 7 - i;
      if (!cpha) begin
        mosi = mo[k];
        repeat (H) @(negedge clk);
        mi[k] = miso;
        sclk = ~cpol;
        repeat (H) @(negedge clk);
        sclk = cpol;
      end else begin
        sclk = ~cpol;
        mosi = mo[k];
        repeat (H) @(negedge clk);
        mi[k] = miso;
        sclk = cpol;
        repeat (H) @(negedge clk);
      end
    end
  endtask

  task automatic session(input int n);
    @(negedge clk);
    ss_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int s = 0; s < n; s++) begin
      logic [7:0] got;
      spi_byte(mo_buf[s], got);
      mi_buf[s] = got;
    end
    repeat (H) @(negedge clk);
    ss_n = 1'b1;
    repeat (3 * H) @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] d);
    @(negedge clk);
    while (!rx_valid) @(negedge clk);
    d = rx_data;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  // Arithmetic reference for the stuffing rule.
  task automatic stuff(input logic [7:0] b, input bit into_mo, inout int n);
    bit two;
    two = (b == 8'h7E) || (b == 8'h7D) || (b == 8'h13) || (b == 8'h11);
    if (into_mo) begin
      mo_buf[n] = two ? 8'h7D : b;
      if (two) mo_buf[n + 1] = b ^ 8'h20;
    end else begin
      exp_buf[n] = two ? 8'h7D : b;
      if (two) exp_buf[n + 1] = b ^ 8'h20;
    end
    n += two ? 2 : 1;
  endtask

  task automatic run_chunk(input string req, input int base);
    logic [7:0] txp [8];
    logic [7:0] rxp [8];
    int n_tx = 0;
    int n_rx = 0;
    for (int j = 0; j < 8; j++) begin
      txp[j] = 8'(base + j);
      rxp[j] = 8'(base + j + 5);
      push_tx(txp[j]);
      stuff(txp[j], 1'b0, n_tx);
      stuff(rxp[j], 1'b1, n_rx);
    end
    for (int s = n_rx; s < 16; s++) mo_buf[s] = 8'h7E;
    session(16);
    for (int s = 0; s < 16; s++) check8(req, mi_buf[s], (s < n_tx) ? exp_buf[s] : 8'h7E);
    for (int j = 0; j < 8; j++) begin
      logic [7:0] d;
      pop_rx(d);
      check8(req, d, rxp[j]);
    end
    @(negedge clk);
    check8(req, {7'b0, rx_valid}, 8'h00);
  endtask

  initial begin
    logic [7:0] d;
    for (int m = 0; m < 8; m++) begin
      do_reset(m);
      check8("R9 tx_ready", {7'b0, tx_ready}, 8'h01);
      check8("R9 rx_valid", {7'b0, rx_valid}, 8'h00);
      mo_buf[0] = 8'h7E;
      session(1);
      check8("R1 first byte", mi_buf[0], 8'h7E);
      if (m == 0) begin
        for (int c = 0; c < 32; c++) run_chunk("R2 R3 R7 sweep", c * 8);
      end else begin
        run_chunk("R7 R2 R3 mode", 8'h78);
        run_chunk("R7 R2 R3 mode", 8'h0C);
      end
    end

    do_reset(0);
    // R3: unescaped control codes and filler are dropped
    mo_buf[0] = 8'h11; mo_buf[1] = 8'h13; mo_buf[2] = 8'h7E; mo_buf[3] = 8'h55;
    session(4);
    pop_rx(d);
    check8("R3 drop reserved", d, 8'h55);
    @(negedge clk);
    check8("R3 nothing else", {7'b0, rx_valid}, 8'h00);

    // R6: half-received escape discarded by select deassertion
    mo_buf[0] = 8'h7D;
    session(1);
    mo_buf[0] = 8'h41;
    session(1);
    pop_rx(d);
    check8("R6 rx escape cleared", d, 8'h41);
    @(negedge clk);
    check8("R6 rx single byte", {7'b0, rx_valid}, 8'h00);

    // R6: unsent escape tail dropped, filler follows
    push_tx(8'h7E);
    repeat (4) @(negedge clk);
    mo_buf[0] = 8'h7E;
    session(1);
    check8("R6 escape head", mi_buf[0], 8'h7D);
    mo_buf[0] = 8'h7E; mo_buf[1] = 8'h7E;
    session(2);
    check8("R6 tail dropped", mi_buf[0], 8'h7E);
    check8("R6 tail dropped", mi_buf[1], 8'h7E);

    // R8: 16-byte transmit queue
    for (int i = 0; i < 16; i++) push_tx(8'(8'h30 + i));
    repeat (2) @(negedge clk);
    check8("R8 tx full", {7'b0, tx_ready}, 8'h00);
    for (int i = 0; i < 16; i++) mo_buf[i] = 8'h7E;
    session(16);
    for (int i = 0; i < 16; i++) check8("R8 tx order", mi_buf[i], 8'(8'h30 + i));
    check8("R8 tx drained", {7'b0, tx_ready}, 8'h01);

    // R4: pause symbol two slots after the twelfth byte
    for (int i = 0; i < 12; i++) mo_buf[i] = 8'(8'h40 + i);
    mo_buf[12] = 8'h7E; mo_buf[13] = 8'h7E;
    session(14);
    for (int i = 0; i < 13; i++) check8("R4 before pause", mi_buf[i], 8'h7E);
    check8("R4 pause symbol", mi_buf[13], 8'h13);

    // R5: continue symbol goes ahead of a waiting escaped payload byte
    push_tx(8'h7E);
    for (int i = 0; i < 9; i++) begin
      pop_rx(d);
      check8("R4 drain order", d, 8'(8'h40 + i));
    end
    repeat (6) @(negedge clk);
    for (int i = 0; i < 4; i++) mo_buf[i] = 8'h7E;
    session(4);
    check8("R4 R5 continue first", mi_buf[0], 8'h11);
    check8("R5 escape head", mi_buf[1], 8'h7D);
    check8("R5 escape tail", mi_buf[2], 8'h5E);
    check8("R1 filler after", mi_buf[3], 8'h7E);
    for (int i = 9; i < 12; i++) begin
      pop_rx(d);
      check8("R4 remaining", d, 8'(8'h40 + i));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule